// File: doc/BRIEF.md
# Current Reference and Current-Loop PI Datapath

This block is the inner loop of an average-current-mode power-factor stage. On every current-loop sample strobe (nominally one per 10 µs) it forms a current reference by multiplying the voltage-loop control word by the magnitude of the line-voltage sample, then scaling the product down by 2^11 or 2^12. It subtracts the sensed inductor-current code from that reference. The resulting error drives an incremental PI regulator with fixed gains. The regulator output is post-scaled by 1/64 and becomes a PWM compare value in timer counts.

The line sample is a 12-bit code whose midpoint, 2048, stands for zero volts on a bipolar input. The block takes the distance of the code from that midpoint, so both half-cycles of the line give the same reference. The compare value is confined between 0 and a loadable ceiling, which comes out of reset at 1862 counts (about 97 % of a 1920-count period). The PI accumulator is confined to the same window so that it cannot wind up. Each result appears a fixed four clocks after its strobe, together with a one-cycle valid pulse.

Top module: `ilp_ref_pi`

## Requirements
- R1: While reset is applied and right after it, the compare value is 0, valid is low, the PI accumulator and the stored previous error are 0, and the ceiling is 1862.
- R2: The line code is taken as its distance from 2048, `mag = |line - 2048|`, so codes 2048+d and 2048-d give the same reference.
- R3: The reference is `(ctrl * mag) >> 11` when the divisor select is 0, and `(ctrl * mag) >> 12` when it is 1, truncated toward zero.
- R4: The error is the reference minus the 10-bit unsigned current code, as a signed value.
- R5: Per sample, the accumulator gains `48*(e - e_prev) + 8*e`, and e_prev then takes the value e.
- R6: The compare value is the accumulator divided by 64, rounded down.
- R7: The accumulator is clamped to the range 0 to ceiling*64 on every update, so the compare value never exceeds the ceiling. A reversed error therefore acts on the very next sample without unwinding first.
- R8: When the ceiling-load input is high at a clock edge, the ceiling takes the value on the ceiling data input. The new ceiling applies to every later accumulation.
- R9: Valid is high for exactly one cycle, on the fourth rising edge counting the edge that samples the strobe. The compare value changes only on that edge.
- R10: Strobes on consecutive clocks each produce their own result in order, one per clock.
- R11: Without a strobe, the compare value holds, no valid pulse appears, and the regulator state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Current-loop sample strobe, one clock wide per sample |
| vctl_word | input | 12 | Voltage-loop control word, unsigned |
| line_code | input | 12 | Line-voltage code, 2048 stands for zero |
| isns_code | input | 10 | Sensed inductor-current code, unsigned |
| div_sel | input | 1 | Reference scaling: 0 gives /2048, 1 gives /4096 |
| cap_load | input | 1 | Load strobe for the compare ceiling |
| cap_value | input | 16 | New compare ceiling in timer counts |
| cmp_value | output | 16 | Duty compare value in timer counts |
| cmp_valid | output | 1 | One-cycle pulse marking a new compare value |

## Verification
The bench uses the default parameters: 12-bit control and line words, a 10-bit current code, gains of 48 and 8, a post-shift of 6 and a reset ceiling of 1862. With these values, a full-scale control word on a line code of 0 gives a reference of 4095. One such sample drives the accumulator past 1862*64, so both clamp edges and the reset ceiling come into play within a few strobes. A chosen error of 3500 after saturation then lands on a compare value that differs clearly between a clamped integrator and a wound-up one.

// File: rtl/ilp_pkg.sv
package ilp_pkg;

    // Default geometry of the current-loop datapath
    localparam int unsigned ILP_CTRL_W   = 12;
    localparam int unsigned ILP_LINE_W   = 12;
    localparam int unsigned ILP_ISNS_W   = 10;
    localparam int unsigned ILP_CMP_W    = 16;
    localparam int unsigned ILP_KP       = 48;
    localparam int unsigned ILP_KI       = 8;
    localparam int unsigned ILP_POST_SH  = 6;
    localparam int unsigned ILP_SH_LO    = 11;
    localparam int unsigned ILP_SH_HI    = 12;
    localparam int unsigned ILP_CAP_RST  = 1862;

    function automatic int unsigned ilp_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilp_line_mag.sv
// Distance of an offset-binary line code from its midpoint.
module ilp_line_mag #(
    parameter int unsigned LINE_W = 12
) (
    input  logic [LINE_W-1:0] code,
    output logic [LINE_W-1:0] mag
);
    localparam logic [LINE_W-1:0] MID = {1'b1, {(LINE_W-1){1'b0}}};

    always_comb begin
        if (code >= MID) mag = code - MID;
        else             mag = MID - code;
    end
endmodule

// File: rtl/ilp_ref_scale.sv
// Control word times line magnitude, scaled by one of two powers of two.
module ilp_ref_scale #(
    parameter int unsigned CTRL_W = 12,
    parameter int unsigned MAG_W  = 12,
    parameter int unsigned SH_LO  = 11,
    parameter int unsigned SH_HI  = 12,
    parameter int unsigned REF_W  = 13
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [MAG_W-1:0]  mag,
    input  logic              sel_hi,
    output logic [REF_W-1:0]  ref_o
);
    localparam int unsigned PROD_W = CTRL_W + MAG_W;

    logic [PROD_W-1:0] prod;

    assign prod = {{MAG_W{1'b0}}, ctrl} * {{CTRL_W{1'b0}}, mag};

    always_comb begin
        if (sel_hi) ref_o = REF_W'(prod >> SH_HI);
        else        ref_o = REF_W'(prod >> SH_LO);
    end
endmodule

// File: rtl/ilp_pi_step.sv
// Incremental PI: delta = KP*(e - e_prev) + KI*e
module ilp_pi_step #(
    parameter int unsigned ERR_W = 14,
    parameter int unsigned INC_W = 22,
    parameter int unsigned KP    = 48,
    parameter int unsigned KI    = 8
) (
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [ERR_W-1:0] err_prev,
    output logic signed [INC_W-1:0] inc
);
    localparam logic signed [INC_W-1:0] KP_S = INC_W'(KP);
    localparam logic signed [INC_W-1:0] KI_S = INC_W'(KI);
    localparam bit          KI_POW2 = (KI != 0) && ((KI & (KI - 1)) == 0);
    localparam int unsigned KI_SH   = (KI > 1) ? $clog2(KI) : 0;

    logic signed [INC_W-1:0] e_x;
    logic signed [INC_W-1:0] p_x;
    logic signed [INC_W-1:0] ki_term;

    assign e_x = INC_W'(err);
    assign p_x = INC_W'(err_prev);

    generate
        if (KI_POW2) begin : g_ki_shift
            assign ki_term = e_x <<< KI_SH;
        end else begin : g_ki_mult
            assign ki_term = e_x * KI_S;
        end
    endgenerate

    assign inc = KP_S * (e_x - p_x) + ki_term;
endmodule

// File: rtl/ilp_acc_sat.sv
// Accumulator update clamped to [0, cap << POST_SH], plus post-scaled output.
module ilp_acc_sat #(
    parameter int unsigned ACC_W   = 24,
    parameter int unsigned INC_W   = 22,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned POST_SH = 6
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic signed [INC_W-1:0] inc,
    input  logic        [CMP_W-1:0] cap,
    output logic signed [ACC_W-1:0] acc_nx,
    output logic        [CMP_W-1:0] cmp_nx
);
    localparam int unsigned SUM_W = ACC_W + 1;

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] hi;
    logic signed [ACC_W-1:0] acc_w;

    assign sum = SUM_W'(acc) + SUM_W'(inc);
    assign hi  = $signed({{(SUM_W-CMP_W-POST_SH){1'b0}}, cap, {POST_SH{1'b0}}});

    always_comb begin
        if (sum < 0)       acc_w = '0;
        else if (sum > hi) acc_w = ACC_W'(hi);
        else               acc_w = ACC_W'(sum);
    end

    assign acc_nx = acc_w;
    assign cmp_nx = CMP_W'(acc_w >>> POST_SH);
endmodule

// File: rtl/ilp_ref_pi.sv
// Current reference multiplier and current-loop PI, four-stage pipeline.
module ilp_ref_pi
    import ilp_pkg::*;
#(
    parameter int unsigned CTRL_W  = ILP_CTRL_W,
    parameter int unsigned LINE_W  = ILP_LINE_W,
    parameter int unsigned ISNS_W  = ILP_ISNS_W,
    parameter int unsigned CMP_W   = ILP_CMP_W,
    parameter int unsigned KP      = ILP_KP,
    parameter int unsigned KI      = ILP_KI,
    parameter int unsigned POST_SH = ILP_POST_SH,
    parameter int unsigned SH_LO   = ILP_SH_LO,
    parameter int unsigned SH_HI   = ILP_SH_HI,
    parameter int unsigned CAP_RST = ILP_CAP_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic [CTRL_W-1:0] vctl_word,
    input  logic [LINE_W-1:0] line_code,
    input  logic [ISNS_W-1:0] isns_code,
    input  logic              div_sel,
    input  logic              cap_load,
    input  logic [CMP_W-1:0]  cap_value,
    output logic [CMP_W-1:0]  cmp_value,
    output logic              cmp_valid
);
    localparam int unsigned MAG_W = LINE_W;
    localparam int unsigned REF_W = CTRL_W + MAG_W - SH_LO;
    localparam int unsigned ERR_W = ilp_max(REF_W, ISNS_W) + 1;
    localparam int unsigned INC_W = ERR_W + $clog2(KP + KI) + 2;
    localparam int unsigned ACC_W = ilp_max(CMP_W + POST_SH + 2, INC_W + 1);

    typedef struct packed {
        // stage 1: captured sample
        logic                    v1;
        logic [CTRL_W-1:0]       ctrl1;
        logic [MAG_W-1:0]        mag1;
        logic [ISNS_W-1:0]       isn1;
        logic                    sel1;
        // stage 2: reference
        logic                    v2;
        logic [REF_W-1:0]        ref2;
        logic [ISNS_W-1:0]       isn2;
        // stage 3: PI increment
        logic                    v3;
        logic signed [INC_W-1:0] inc3;
        logic signed [ERR_W-1:0] eprev;
        // stage 4: accumulator and output
        logic signed [ACC_W-1:0] acc;
        logic [CMP_W-1:0]        cmp;
        logic                    vout;
        // compare ceiling
        logic [CMP_W-1:0]        cap;
    } ilp_st_t;

    ilp_st_t st_d, st_q;

    logic [MAG_W-1:0]        mag_w;
    logic [REF_W-1:0]        ref_w;
    logic signed [ERR_W-1:0] err_w;
    logic signed [INC_W-1:0] inc_w;
    logic signed [ACC_W-1:0] acc_w;
    logic [CMP_W-1:0]        cmp_w;
    logic [CMP_W-1:0]        cap_lim;

    ilp_line_mag #(.LINE_W(LINE_W)) u_mag (
        .code (line_code),
        .mag  (mag_w)
    );

    ilp_ref_scale #(
        .CTRL_W (CTRL_W),
        .MAG_W  (MAG_W),
        .SH_LO  (SH_LO),
        .SH_HI  (SH_HI),
        .REF_W  (REF_W)
    ) u_ref (
        .ctrl   (st_q.ctrl1),
        .mag    (st_q.mag1),
        .sel_hi (st_q.sel1),
        .ref_o  (ref_w)
    );

    assign err_w = $signed({{(ERR_W-REF_W){1'b0}}, st_q.ref2})
                 - $signed({{(ERR_W-ISNS_W){1'b0}}, st_q.isn2});

    ilp_pi_step #(
        .ERR_W (ERR_W),
        .INC_W (INC_W),
        .KP    (KP),
        .KI    (KI)
    ) u_pi (
        .err      (err_w),
        .err_prev (st_q.eprev),
        .inc      (inc_w)
    );

    ilp_acc_sat #(
        .ACC_W   (ACC_W),
        .INC_W   (INC_W),
        .CMP_W   (CMP_W),
        .POST_SH (POST_SH)
    ) u_sat (
        .acc    (st_q.acc),
        .inc    (st_q.inc3),
        .cap    (st_q.cap),
        .acc_nx (acc_w),
        .cmp_nx (cmp_w)
    );

    always_comb begin
        st_d = st_q;

        st_d.v1 = smp_stb;
        if (smp_stb) begin
            st_d.ctrl1 = vctl_word;
            st_d.mag1  = mag_w;
            st_d.isn1  = isns_code;
            st_d.sel1  = div_sel;
        end

        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.ref2 = ref_w;
            st_d.isn2 = st_q.isn1;
        end

        st_d.v3 = st_q.v2;
        if (st_q.v2) begin
            st_d.inc3  = inc_w;
            st_d.eprev = err_w;
        end

        st_d.vout = st_q.v3;
        if (st_q.v3) begin
            st_d.acc = acc_w;
            st_d.cmp = cmp_w;
        end

        if (cap_load) st_d.cap = cap_value;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            st_q.cap <= CMP_W'(CAP_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_value = st_q.cmp;
    assign cmp_valid = st_q.vout;
    assign cap_lim   = st_q.cap;

endmodule

// File: rtl/ilp_ref_pi_chk.sv
module ilp_ref_pi_chk #(
    parameter int unsigned CMP_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_stb,
    input logic             cap_load,
    input logic [CMP_W-1:0] cap_value,
    input logic [CMP_W-1:0] cap_lim,
    input logic [CMP_W-1:0] cmp_value,
    input logic             cmp_valid
);
    // R1: reset clears the output
    assert_rst_clear_R1: assert property (@(posedge clk)
        rst |=> (cmp_value == '0 && !cmp_valid));

    // R9: a strobe produces valid four edges later
    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(smp_stb, 4) && !$past(rst, 4) && !$past(rst, 3)
         && !$past(rst, 2) && !$past(rst, 1)) |-> cmp_valid);

    // R9: no valid without a strobe four edges before
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |-> $past(smp_stb, 4));

    // R7: output never above the ceiling in force at accumulation
    assert_under_cap_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !$past(cap_load)) |-> (cmp_value <= cap_lim));

    // R11: output holds between results
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!cmp_valid && !$past(rst)) |-> $stable(cmp_value));

    // R8: ceiling load takes the presented value
    assert_cap_load_R8: assert property (@(posedge clk) disable iff (rst)
        cap_load |=> (cap_lim == $past(cap_value)));
endmodule

bind ilp_ref_pi ilp_ref_pi_chk #(.CMP_W(CMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_stb   (smp_stb),
    .cap_load  (cap_load),
    .cap_value (cap_value),
    .cap_lim   (cap_lim),
    .cmp_value (cmp_value),
    .cmp_valid (cmp_valid)
);

// File: tb/ilp_ref_pi_bench.sv
`timescale 1ns/1ps
module ilp_ref_pi_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [11:0] vctl_word = '0;
    logic [11:0] line_code = 12'd2048;
    logic [9:0]  isns_code = '0;
    logic        div_sel = 1'b0;
    logic        cap_load = 1'b0;
    logic [15:0] cap_value = '0;
    logic [15:0] cmp_value;
    logic        cmp_valid;

    ilp_ref_pi u_ilp_ref_pi (
        .clk       (clk),
        .rst       (rst),
        .smp_stb   (smp_stb),
        .vctl_word (vctl_word),
        .line_code (line_code),
        .isns_code (isns_code),
        .div_sel   (div_sel),
        .cap_load  (cap_load),
        .cap_value (cap_value),
        .cmp_value (cmp_value),
        .cmp_valid (cmp_valid)
    );

    always #4 clk = ~clk;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string ph = "R1";

    // behavioural model state
    int m_acc = 0;
    int m_eprev = 0;
    int m_cap = 1862;
    int due_q[$];
    int val_q[$];
    int exp_cmp = 0;
    int exp_v;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            exp_v = 0;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                exp_v   = 1;
                exp_cmp = val_q[0];
                void'(due_q.pop_front());
                void'(val_q.pop_front());
            end
            chk({ph, " valid"}, int'(cmp_valid), exp_v);
            chk({ph, " cmp"}, int'(cmp_value), exp_cmp);
        end
    end

    task automatic put(input int ctrl, input int line, input int isn, input int sel);
        int mag, rf, e, inc, s;
        @(negedge clk); #1;
        smp_stb   = 1'b1;
        cap_load  = 1'b0;
        vctl_word = 12'(ctrl);
        line_code = 12'(line);
        isns_code = 10'(isn);
        div_sel   = sel[0];
        mag = (line >= 2048) ? line - 2048 : 2048 - line;
        rf  = (ctrl * mag) >> (sel ? 12 : 11);
        e   = rf - isn;
        inc = 48 * (e - m_eprev) + 8 * e;
        m_eprev = e;
        s = m_acc + inc;
        if (s < 0) s = 0;
        if (s > m_cap * 64) s = m_cap * 64;
        m_acc = s;
        due_q.push_back(cyc + 4);
        val_q.push_back(s / 64);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            smp_stb  = 1'b0;
            cap_load = 1'b0;
        end
    endtask

    task automatic load_cap(input int v);
        @(negedge clk); #1;
        smp_stb   = 1'b0;
        cap_load  = 1'b1;
        cap_value = 16'(v);
        m_cap     = v;
        gap(1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog expired got 0 expected 1");
            finish_run();
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 cmp in reset", int'(cmp_value), 0);
        chk("R1 valid in reset", int'(cmp_valid), 0);
        @(negedge clk); #1; rst = 1'b0;
        gap(2);
        chk("R1 cmp after reset", int'(cmp_value), 0);

        // R3/R5/R6: hand-computed first sample, ref 488, inc 27328 -> 427
        ph = "R6";
        put(1000, 3048, 0, 0);
        gap(6);
        chk("R6 first sample", int'(cmp_value), 427);

        // R2: mirrored line codes
        ph = "R2";
        put(1000, 1048, 0, 0); gap(5);
        put(1500, 2048 + 700, 20, 0); gap(5);
        put(1500, 2048 - 700, 20, 0); gap(5);

        // R3: divisor by 4096
        ph = "R3";
        put(3000, 3500, 100, 1); gap(5);
        put(3000, 600, 100, 1); gap(5);

        // R4/R7 low clamp: current above reference
        ph = "R4";
        put(100, 2200, 900, 0); gap(5);
        put(100, 2200, 1023, 1); gap(5);
        chk("R7 low clamp", int'(cmp_value), 0);

        // R7/R8: saturate at the reset ceiling of 1862
        ph = "R7";
        for (int i = 0; i < 4; i++) begin put(4095, 0, 0, 0); gap(2); end
        gap(5);
        chk("R8 reset ceiling", int'(cmp_value), 1862);

        // R8: new ceiling, then R7 anti-windup step
        ph = "R8";
        load_cap(1000);
        for (int i = 0; i < 10; i++) begin put(4095, 0, 0, 0); gap(1); end
        gap(5);
        chk("R8 loaded ceiling", int'(cmp_value), 1000);
        ph = "R7";
        put(4095, 0, 595, 0); gap(5);
        chk("R7 no windup", int'(cmp_value), 991);

        // R10: back-to-back strobes
        ph = "R10";
        load_cap(1862);
        for (int i = 0; i < 12; i++) put(500 + 300 * i, 300 * i, 40 * i, i % 2);
        gap(6);

        // R11/R10: mixed random traffic with idle gaps
        ph = "R11";
        for (int i = 0; i < 300; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            put(int'(seed[27:16]), int'(seed[15:4]), int'(seed[25:16]), int'(seed[30]));
            gap(int'(seed[3:2]));
        end
        gap(8);
        finish_run();
    end
endmodule